// File: doc/BRIEF.md
# Converter Serial Output Shifter

This block is the digital read-out side of a 12-bit sampling converter. A conversion engine, not part of this block, hands over a parallel result with a one-cycle load strobe. An external master reads the result over a three-wire link. The master supplies a serial clock and watches a data line that the block drives only while its output-enable is high.

A read frame lasts sixteen serial clock periods. It carries four zero pad bits, then the result from MSB down to LSB. The block counts edges of the external clock to pick the bit it presents. It releases the line after the sixteenth falling edge. Clocks beyond that start the frame over, and the line is then never released.

A falling edge on the active-low conversion-start input puts the frame back to its beginning, but only while the serial clock is low. The external clock and conversion-start are brought into a faster system clock through two-flop synchronizers, and edges are found in that domain. A result loaded while a frame is under way is parked in a shadow register. It takes effect at the next conversion-start reset. The busy flag from the engine is passed straight through.

Top module: `adc_serial_shifter`

## Requirements
- R1: After reset, sdo_oe and sdo are both 0.
- R2: The first rising serial clock edge of a fresh frame raises sdo_oe and presents frame bit 0, a pad zero.
- R3: Frame bit k is shown from the k-th falling edge until the next falling edge. Bits 0 to 3 are 0, and bits 4 to 15 are the result with bit 11 first and bit 0 last.
- R4: The sixteenth falling edge of a frame drops sdo_oe to 0.
- R5: A rising edge after the line has been released restarts the frame at bit 0 with sdo_oe high. From then on, sdo_oe stays high through later frame ends and clock pauses.
- R6: A conversion-start falling edge while the serial clock is low returns to a fresh frame: sdo_oe goes to 0, and the next read begins again at bit 0.
- R7: A conversion-start falling edge while the serial clock is high has no effect on the bit position or on sdo_oe.
- R8: While the serial clock is held low mid-frame, sdo and sdo_oe hold, and the frame resumes at the next bit.
- R9: A result loaded in a fresh frame is used by the next read. A result loaded mid-frame leaves the current frame unchanged and takes effect at the next conversion-start reset.
- R10: A result load in the same system cycle as a conversion-start reset becomes the word of the next frame, and any result held in the shadow register is discarded.
- R11: busy_out equals busy_in combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_data | input | 12 | Parallel conversion result |
| res_load | input | 1 | One-cycle strobe that accepts res_data |
| busy_in | input | 1 | Busy flag from the conversion engine |
| sclk_in | input | 1 | External serial clock (asynchronous) |
| cnv_n_in | input | 1 | Active-low conversion-start (asynchronous) |
| busy_out | output | 1 | Pass-through of busy_in |
| sdo | output | 1 | Serial data, valid while sdo_oe is high |
| sdo_oe | output | 1 | Serial data output-enable |

## Verification
Two functions can land in the same system cycle: a result load and a conversion-start reset. Both want to write the word that is presented. The bench first parks a value in the shadow register with a mid-frame load. It then times a second load to arrive in exactly the cycle where the synchronized conversion-start edge clears the frame. It judges the outcome by reading a whole frame: the second value must appear and the parked one must not. A second coincidence is also provoked: a conversion-start edge that arrives while the serial clock is high. It is judged by checking that the following bits continue from the same position.

// File: rtl/adc_shift_pkg.sv
package adc_shift_pkg;
  localparam int unsigned DEF_RES_W  = 12;
  localparam int unsigned DEF_PAD_W  = 4;
  localparam int unsigned DEF_STAGES = 2;

  typedef struct packed {
    logic rise;
    logic fall;
  } edge_ev_t;
endpackage

// File: rtl/adc_edge_sync.sv
module adc_edge_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    din,
  output logic                    level,
  output adc_shift_pkg::edge_ev_t ev
);
  // STAGES synchronizer flops plus one history flop for edge detection
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {(STAGES+1){RST_VAL}};
    else        chain <= {chain[STAGES-1:0], din};
  end

  assign level   = chain[STAGES-1];
  assign ev.rise = chain[STAGES-1] & ~chain[STAGES];
  assign ev.fall = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/adc_frame_counter.sv
module adc_frame_counter #(
  parameter int unsigned FRAME_LEN = 16,
  localparam int unsigned CNT_W    = $clog2(FRAME_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  adc_shift_pkg::edge_ev_t sclk_ev,
  input  logic             cnv_rst,
  output logic [CNT_W-1:0] pos,
  output logic             oe,
  output logic             in_frame
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] DONE = CNT_W'(FRAME_LEN);

  logic overrun;

  // Position after a falling edge while driving
  function automatic logic [CNT_W-1:0] step_pos(logic [CNT_W-1:0] p, logic wrap);
    if (p != LAST) return p + 1'b1;
    return wrap ? '0 : DONE;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos     <= '0;
      oe      <= 1'b0;
      overrun <= 1'b0;
    end else if (cnv_rst) begin
      pos     <= '0;
      oe      <= 1'b0;
      overrun <= 1'b0;
    end else if (sclk_ev.rise) begin
      if (pos == DONE) begin
        pos     <= '0;
        oe      <= 1'b1;
        overrun <= 1'b1;
      end else begin
        oe <= 1'b1;
      end
    end else if (sclk_ev.fall && oe) begin
      pos <= step_pos(pos, overrun);
      if (pos == LAST && !overrun) oe <= 1'b0;
    end
  end

  assign in_frame = oe || (pos != '0);

  assert_pos_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pos <= DONE);
  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_ev.rise && !oe && pos == '0 && !cnv_rst) |=> (oe && pos == '0));
  assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_ev.fall && oe && pos == LAST && !overrun && !cnv_rst) |=> !oe);
  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && oe && !cnv_rst) |=> oe);
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_rst |=> (!oe && pos == '0));
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk_ev.rise && !sclk_ev.fall && !cnv_rst) |=> ($stable(pos) && $stable(oe)));
endmodule

// File: rtl/adc_result_store.sv
module adc_result_store #(
  parameter int unsigned RES_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RES_W-1:0] data,
  input  logic             load,
  input  logic             in_frame,
  input  logic             clear,
  output logic [RES_W-1:0] word
);
  logic [RES_W-1:0] shadow;
  logic             pending;
  logic             direct;

  assign direct = load && (!in_frame || clear);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word    <= '0;
      shadow  <= '0;
      pending <= 1'b0;
    end else if (direct) begin
      word    <= data;
      pending <= 1'b0;
    end else if (load) begin
      shadow  <= data;
      pending <= 1'b1;
    end else if (clear && pending) begin
      word    <= shadow;
      pending <= 1'b0;
    end
  end

  assert_shadow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frame && !clear) |=> $stable(word));
  assert_collide_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (load && clear) |=> (word == $past(data)));
endmodule

// File: rtl/adc_serial_shifter.sv
module adc_serial_shifter #(
  parameter int unsigned RES_W  = adc_shift_pkg::DEF_RES_W,
  parameter int unsigned PAD_W  = adc_shift_pkg::DEF_PAD_W,
  parameter int unsigned STAGES = adc_shift_pkg::DEF_STAGES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RES_W-1:0] res_data,
  input  logic             res_load,
  input  logic             busy_in,
  input  logic             sclk_in,
  input  logic             cnv_n_in,
  output logic             busy_out,
  output logic             sdo,
  output logic             sdo_oe
);
  localparam int unsigned FRAME_LEN = RES_W + PAD_W;
  localparam int unsigned CNT_W     = $clog2(FRAME_LEN + 1);

  adc_shift_pkg::edge_ev_t sclk_ev, cnv_ev;
  logic             sclk_lvl, cnv_lvl;
  logic             cnv_rst;
  logic [CNT_W-1:0] pos;
  logic             in_frame;
  logic [RES_W-1:0] word;

  // Bit of the padded frame at a given position: pad zeros, then MSB first
  function automatic logic frame_bit(logic [RES_W-1:0] w, logic [CNT_W-1:0] idx);
    logic [RES_W-1:0] sh;
    if (int'(idx) < PAD_W || int'(idx) >= FRAME_LEN) return 1'b0;
    sh = w << (int'(idx) - PAD_W);
    return sh[RES_W-1];
  endfunction

  adc_edge_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) u_sclk_sync (
    .clk(clk), .rst_n(rst_n), .din(sclk_in), .level(sclk_lvl), .ev(sclk_ev));

  adc_edge_sync #(.STAGES(STAGES), .RST_VAL(1'b1)) u_cnv_sync (
    .clk(clk), .rst_n(rst_n), .din(cnv_n_in), .level(cnv_lvl), .ev(cnv_ev));

  // conversion-start edge counts only while the serial clock is low
  assign cnv_rst = cnv_ev.fall && !sclk_lvl;

  adc_frame_counter #(.FRAME_LEN(FRAME_LEN)) u_counter (
    .clk(clk), .rst_n(rst_n), .sclk_ev(sclk_ev), .cnv_rst(cnv_rst),
    .pos(pos), .oe(sdo_oe), .in_frame(in_frame));

  adc_result_store #(.RES_W(RES_W)) u_store (
    .clk(clk), .rst_n(rst_n), .data(res_data), .load(res_load),
    .in_frame(in_frame), .clear(cnv_rst), .word(word));

  assign sdo      = sdo_oe && frame_bit(word, pos);
  assign busy_out = busy_in;

  assert_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_oe |-> !sdo);
  assert_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnv_ev.fall && sclk_lvl && !sclk_ev.rise && !sclk_ev.fall) |=> ($stable(sdo_oe) && $stable(pos)));
  // cnv_lvl only feeds edge detection
  logic unused_cnv_lvl;
  assign unused_cnv_lvl = cnv_lvl;
endmodule

// File: tb/adc_serial_shifter_tb_top.sv
module adc_serial_shifter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [11:0] res_data = '0;
  logic res_load = 1'b0;
  logic busy_in = 1'b0;
  logic sclk_in = 1'b0;
  logic cnv_n_in = 1'b1;
  logic busy_out, sdo, sdo_oe;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  adc_serial_shifter dut_i (
    .clk(clk), .rst_n(rst_n), .res_data(res_data), .res_load(res_load),
    .busy_in(busy_in), .sclk_in(sclk_in), .cnv_n_in(cnv_n_in),
    .busy_out(busy_out), .sdo(sdo), .sdo_oe(sdo_oe));

  function automatic logic want_bit(logic [11:0] w, int k);
    logic [15:0] fr;
    fr = {4'b0000, w};
    return fr[15 - k];
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sclk_hi();
    @(negedge clk); sclk_in = 1'b1; idle(4);
  endtask

  task automatic sclk_lo();
    @(negedge clk); sclk_in = 1'b0; idle(4);
  endtask

  task automatic cnv_pulse();
    @(negedge clk); cnv_n_in = 1'b0; idle(4);
    cnv_n_in = 1'b1; idle(4);
  endtask

  task automatic load(logic [11:0] v);
    @(negedge clk); res_data = v; res_load = 1'b1;
    @(negedge clk); res_load = 1'b0;
  endtask

  // read bits first..last of a frame for word w; flags every bit check
  task automatic read_bits(logic [11:0] w, int first, int last, string req);
    for (int k = first; k <= last; k++) begin
      sclk_hi();
      chk(req, $sformatf("oe high bit %0d", k), 32'(sdo_oe), 32'd1);
      chk("R3", $sformatf("sdo high bit %0d", k), 32'(sdo), 32'(want_bit(w, k)));
      sclk_lo();
      if (k < 15) begin
        chk("R3", $sformatf("sdo low bit %0d", k + 1), 32'(sdo), 32'(want_bit(w, k + 1)));
      end
    end
  endtask

  task automatic t_reset();
    chk("R1", "oe after reset", 32'(sdo_oe), 32'd0);
    chk("R1", "sdo after reset", 32'(sdo), 32'd0);
  endtask

  task automatic t_busy();
    busy_in = 1'b1; #1;
    chk("R11", "busy high", 32'(busy_out), 32'd1);
    busy_in = 1'b0; #1;
    chk("R11", "busy low", 32'(busy_out), 32'd0);
  endtask

  task automatic t_full_frame();
    load(12'hA5C);
    sclk_hi();
    chk("R2", "oe on first rise", 32'(sdo_oe), 32'd1);
    chk("R2", "first bit zero", 32'(sdo), 32'd0);
    sclk_lo();
    chk("R3", "sdo bit 1", 32'(sdo), 32'd0);
    read_bits(12'hA5C, 1, 15, "R3");
    chk("R4", "released after 16th fall", 32'(sdo_oe), 32'd0);
  endtask

  task automatic t_overrun();
    sclk_hi();
    chk("R5", "extra rise drives", 32'(sdo_oe), 32'd1);
    chk("R5", "extra rise bit 0", 32'(sdo), 32'd0);
    sclk_lo();
    read_bits(12'hA5C, 1, 15, "R5");
    chk("R5", "still driven after frame end", 32'(sdo_oe), 32'd1);
    idle(40);
    chk("R5", "still driven while clock stopped", 32'(sdo_oe), 32'd1);
    cnv_pulse();
    chk("R6", "cnv reset releases", 32'(sdo_oe), 32'd0);
    read_bits(12'hA5C, 0, 15, "R6");
    chk("R4", "released after reread", 32'(sdo_oe), 32'd0);
    cnv_pulse();
  endtask

  task automatic t_cnv_high();
    read_bits(12'hA5C, 0, 5, "R7");
    sclk_hi();
    cnv_pulse();
    chk("R7", "oe kept with clock high", 32'(sdo_oe), 32'd1);
    chk("R7", "bit 6 kept", 32'(sdo), 32'(want_bit(12'hA5C, 6)));
    sclk_lo();
    chk("R7", "continues at bit 7", 32'(sdo), 32'(want_bit(12'hA5C, 7)));
    read_bits(12'hA5C, 7, 15, "R7");
    cnv_pulse();
  endtask

  task automatic t_pause();
    read_bits(12'hA5C, 0, 7, "R8");
    idle(60);
    chk("R8", "oe held in pause", 32'(sdo_oe), 32'd1);
    chk("R8", "bit 8 held in pause", 32'(sdo), 32'(want_bit(12'hA5C, 8)));
    read_bits(12'hA5C, 8, 15, "R8");
    cnv_pulse();
  endtask

  task automatic t_shadow();
    read_bits(12'hA5C, 0, 4, "R9");
    load(12'h3C1);
    read_bits(12'hA5C, 5, 15, "R9");
    sclk_hi();
    chk("R9", "wrap still old word bit 0", 32'(sdo), 32'd0);
    sclk_lo();
    read_bits(12'hA5C, 1, 15, "R9");
    cnv_pulse();
    read_bits(12'h3C1, 0, 15, "R9");
    cnv_pulse();
  endtask

  task automatic t_collide();
    read_bits(12'h3C1, 0, 3, "R10");
    load(12'h0F0);
    read_bits(12'h3C1, 4, 15, "R10");
    @(negedge clk); cnv_n_in = 1'b0;
    @(negedge clk);
    @(negedge clk); res_data = 12'h96B; res_load = 1'b1;
    @(negedge clk); res_load = 1'b0;
    idle(4);
    cnv_n_in = 1'b1; idle(4);
    chk("R10", "released after collision", 32'(sdo_oe), 32'd0);
    read_bits(12'h96B, 0, 15, "R10");
    cnv_pulse();
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(3);
    t_reset();
    t_busy();
    t_full_frame();
    t_overrun();
    t_cnv_high();
    t_pause();
    t_shadow();
    t_collide();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule